// File: doc/BRIEF.md
# DMA Channel Register Bank with Shared Interrupt

This block is the bus-facing register file and interrupt logic of a multi-channel DMA controller. The default build has four channels. Each channel owns a 16-byte window that holds a source address, a destination address, a transfer cycle count and a control word. The control word combines the run bit, the finish and error status flags, their interrupt enables, burst mode and a field of transfer configuration. The transfer datapath is a separate engine. This bank hands it the register contents and a one-cycle start pulse, and takes back the finish and error pulses and the live count of cycles still to run.

Software starts a channel by setting the run bit. It aborts a channel by writing the run bit and both interrupt enables back to zero. It acknowledges an event by writing the control word with the status bit at zero. A finish or error from the engine clears the run bit and latches its status flag. One interrupt line gathers every channel's enabled status.

Top module: `dma_regbank`

## Requirements
- R1: Channel c decodes at byte address c*16. Offset 0 is the source address, 4 the destination address, 8 the cycle count and 12 the control word. Source and destination hold and read back all 32 bits.
- R2: The cycle count register keeps its low CNT_W bits (24 by default) and reads zero above them. While the channel's run bit is 1, a read of it returns that channel's `eng_remain` slice in place of the stored value.
- R3: Control word layout: bit 0 run, bit 1 finish status, bit 2 finish interrupt enable, bit 3 burst, bit 4 error status, bit 5 error interrupt enable, bits 31:6 configuration. The non-status bits take the value written and read back. Burst and configuration drive `eng_burst` and `eng_cfg`.
- R4: Writing 0 to a status bit clears it. Writing 1 leaves it as it was, so software can never set a status bit.
- R5: An `eng_done` or `eng_err` pulse in a cycle where the run bit is 1 sets the finish or error status at that clock edge and clears the run bit. While the run bit is 0 the pulse has no effect. If the event and a control write land in the same cycle, the status set and the run clear win over the write.
- R6: When the run bit changes from 0 to 1, `eng_start` pulses for exactly the one cycle after the write edge. During that cycle `eng_src`, `eng_dst` and `eng_cnt` show the channel's current register values.
- R7: `irq` is 1 exactly when some channel has (finish status AND finish enable) OR (error status AND error enable). It follows the registered bits in the same cycle.
- R8: A control write with run = 0 stops the channel. `eng_run` drops, no start pulse follows, and later engine events leave the channel unchanged.
- R9: Every register resets to zero. A write whose address bits [1:0] are not zero changes nothing, and a read at such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| eng_start | output | NCH | One-cycle start pulse per channel |
| eng_run | output | NCH | Run bit per channel |
| eng_burst | output | NCH | Burst bit per channel |
| eng_src | output | NCH*32 | Source address per channel |
| eng_dst | output | NCH*32 | Destination address per channel |
| eng_cnt | output | NCH*CNT_W | Programmed cycle count per channel |
| eng_cfg | output | NCH*26 | Configuration field per channel |
| eng_remain | input | NCH*CNT_W | Cycles outstanding, from the engine |
| eng_done | input | NCH | Finish event pulse per channel |
| eng_err | input | NCH | Error event pulse per channel |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes, status updates and run-bit changes are all due at the clock edge that samples the stimulus, and `irq` follows at that same edge. `eng_start` is due in the cycle after the edge that sets the run bit. `rdata` is combinational in `addr` and `eng_remain`, so it is due in the same cycle as the address. The bench drives inputs on the falling edge and compares every output with its behavioural model one time unit later, so each result is sampled in the cycle where it is due. Directed reads with hand-computed values then cover event and write collisions, masked interrupts, aborts and misaligned addresses.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DATA_W = 32;
   localparam int CFG_W  = 26;
   localparam int BIT_FIN = 1;
   localparam int BIT_ERR = 4;

   typedef enum logic [1:0] {
      RS_SRC  = 2'd0,
      RS_DST  = 2'd1,
      RS_CNT  = 2'd2,
      RS_CTRL = 2'd3
   } reg_sel_e;

   // control word, MSB first: cfg[31:6], eie, err, burst, fie, fin, run
   typedef struct packed {
      logic [CFG_W-1:0] cfg;
      logic             eie;
      logic             err;
      logic             burst;
      logic             fie;
      logic             fin;
      logic             run;
   } ctrl_t;
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
   import dma_rb_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int ADDR_W = 6
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NCH-1:0]    wr_chan_o,
   output reg_sel_e          sel_o,
   output logic [ADDR_W-5:0] chan_o,
   output logic              aligned_o
);
   timeunit 1ns;
   timeprecision 100ps;

   assign chan_o    = addr[ADDR_W-1:4];
   assign sel_o     = reg_sel_e'(addr[3:2]);
   assign aligned_o = (addr[1:0] == 2'b00);

   always_comb begin
      wr_chan_o = '0;
      if (wr_en && aligned_o) wr_chan_o = NCH'(1) << chan_o;
   end

   always_comb begin
      // R9
      misaligned_block_chk: assert (aligned_o || (wr_chan_o == '0));
      // R1
      one_target_chk: assert ($onehot0(wr_chan_o));
   end
endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
   import dma_rb_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  reg_sel_e          sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              done_i,
   input  logic              err_i,
   input  logic [CNT_W-1:0]  remain_i,
   output logic [DATA_W-1:0] src_o,
   output logic [DATA_W-1:0] dst_o,
   output logic [CNT_W-1:0]  cnt_o,
   output ctrl_t             ctrl_o,
   output logic              start_o,
   output logic [DATA_W-1:0] rd_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [DATA_W-1:0] src_q, dst_q;
   logic [CNT_W-1:0]  cnt_q;
   ctrl_t             ctrl_q, ctrl_nxt;
   logic              run_d;
   logic              ctrl_wr;
   logic [CNT_W-1:0]  cnt_view;

   assign ctrl_wr = wr_i && (sel_i == RS_CTRL);

   always_comb begin
      ctrl_nxt = ctrl_q;
      if (ctrl_wr) begin
         ctrl_nxt     = ctrl_t'(wdata_i);
         ctrl_nxt.fin = ctrl_q.fin & wdata_i[BIT_FIN];
         ctrl_nxt.err = ctrl_q.err & wdata_i[BIT_ERR];
      end
      if (ctrl_q.run && done_i) begin
         ctrl_nxt.fin = 1'b1;
         ctrl_nxt.run = 1'b0;
      end
      if (ctrl_q.run && err_i) begin
         ctrl_nxt.err = 1'b1;
         ctrl_nxt.run = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         run_d  <= 1'b0;
      end else begin
         run_d  <= ctrl_q.run;
         ctrl_q <= ctrl_nxt;
         if (wr_i && sel_i == RS_SRC) src_q <= wdata_i;
         if (wr_i && sel_i == RS_DST) dst_q <= wdata_i;
         if (wr_i && sel_i == RS_CNT) cnt_q <= wdata_i[CNT_W-1:0];
      end
   end

   assign start_o  = ctrl_q.run & ~run_d;
   assign cnt_view = ctrl_q.run ? remain_i : cnt_q;

   always_comb begin
      unique case (sel_i)
         RS_SRC:  rd_o = src_q;
         RS_DST:  rd_o = dst_q;
         RS_CNT:  rd_o = DATA_W'(cnt_view);
         default: rd_o = ctrl_q;
      endcase
   end

   assign src_o  = src_q;
   assign dst_o  = dst_q;
   assign cnt_o  = cnt_q;
   assign ctrl_o = ctrl_q;

   // R5
   fin_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.fin) |-> $past(ctrl_q.run && done_i));
   // R5
   err_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.err) |-> $past(ctrl_q.run && err_i));
   // R4
   fin_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q.fin) |-> $past(ctrl_wr && !wdata_i[BIT_FIN]));
   // R8
   run_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q.run) |-> $past(ctrl_wr || done_i || err_i));
   // R6
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] fin_i,
   input  logic [NCH-1:0] fie_i,
   input  logic [NCH-1:0] err_i,
   input  logic [NCH-1:0] eie_i,
   output logic           irq_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [NCH-1:0] req;

   for (genvar c = 0; c < NCH; c++) begin : g_req
      assign req[c] = (fin_i[c] & fie_i[c]) | (err_i[c] & eie_i[c]);
   end

   assign irq_o = |req;

   // R7
   irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|(fin_i | err_i)));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
   import dma_rb_pkg::*;
#(
   parameter  int NCH    = 4,
   parameter  int CNT_W  = 24,
   localparam int ADDR_W = $clog2(NCH) + 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output logic [NCH-1:0]       eng_start,
   output logic [NCH-1:0]       eng_run,
   output logic [NCH-1:0]       eng_burst,
   output logic [NCH*32-1:0]    eng_src,
   output logic [NCH*32-1:0]    eng_dst,
   output logic [NCH*CNT_W-1:0] eng_cnt,
   output logic [NCH*26-1:0]    eng_cfg,
   input  logic [NCH*CNT_W-1:0] eng_remain,
   input  logic [NCH-1:0]       eng_done,
   input  logic [NCH-1:0]       eng_err,
   output logic                 irq
);
   timeunit 1ns;
   timeprecision 100ps;

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end

   logic [NCH-1:0]    wr_chan;
   reg_sel_e          sel;
   logic [ADDR_W-5:0] chan;
   logic              aligned;
   logic [DATA_W-1:0] ch_rd [NCH];
   ctrl_t             ch_ctrl [NCH];
   logic [NCH-1:0]    fin_v, fie_v, err_v, eie_v;

   dma_rb_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_chan_o (wr_chan),
      .sel_o     (sel),
      .chan_o    (chan),
      .aligned_o (aligned)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dma_rb_chan #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_i     (wr_chan[c]),
         .sel_i    (sel),
         .wdata_i  (wdata),
         .done_i   (eng_done[c]),
         .err_i    (eng_err[c]),
         .remain_i (eng_remain[c*CNT_W +: CNT_W]),
         .src_o    (eng_src[c*DATA_W +: DATA_W]),
         .dst_o    (eng_dst[c*DATA_W +: DATA_W]),
         .cnt_o    (eng_cnt[c*CNT_W +: CNT_W]),
         .ctrl_o   (ch_ctrl[c]),
         .start_o  (eng_start[c]),
         .rd_o     (ch_rd[c])
      );
      assign eng_run[c]               = ch_ctrl[c].run;
      assign eng_burst[c]             = ch_ctrl[c].burst;
      assign eng_cfg[c*CFG_W +: CFG_W] = ch_ctrl[c].cfg;
      assign fin_v[c] = ch_ctrl[c].fin;
      assign fie_v[c] = ch_ctrl[c].fie;
      assign err_v[c] = ch_ctrl[c].err;
      assign eie_v[c] = ch_ctrl[c].eie;
   end

   assign rdata = aligned ? ch_rd[chan] : '0;

   dma_rb_irq #(.NCH(NCH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .fin_i (fin_v),
      .fie_i (fie_v),
      .err_i (err_v),
      .eie_i (eie_v),
      .irq_o (irq)
   );

   // R6
   start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_start) |-> (|eng_run));
endmodule

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  eng_start, eng_run, eng_burst;
   logic [127:0] eng_src, eng_dst;
   logic [95:0] eng_cnt;
   logic [103:0] eng_cfg;
   logic [95:0] eng_remain = '0;
   logic [3:0]  eng_done = '0, eng_err = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   always #2.5 clk = ~clk;

   dma_regbank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .eng_start(eng_start), .eng_run(eng_run),
      .eng_burst(eng_burst), .eng_src(eng_src), .eng_dst(eng_dst),
      .eng_cnt(eng_cnt), .eng_cfg(eng_cfg), .eng_remain(eng_remain),
      .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
   );

   // behavioural reference model
   logic [31:0] m_src [4];
   logic [31:0] m_dst [4];
   logic [23:0] m_cnt [4];
   logic [31:0] m_ctl [4];
   bit          m_run_d [4];

   always @(posedge clk) begin
      for (int c = 0; c < 4; c++) begin
         if (!rst_n) begin
            m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; m_ctl[c] = 0; m_run_d[c] = 0;
         end else begin
            logic [31:0] old;
            old = m_ctl[c];
            m_run_d[c] = old[0];
            if (wr_en && addr[1:0] == 0 && addr[5:4] == c) begin
               case (addr[3:2])
                  0: m_src[c] = wdata;
                  1: m_dst[c] = wdata;
                  2: m_cnt[c] = wdata[23:0];
                  default: begin
                     m_ctl[c] = wdata;
                     m_ctl[c][1] = old[1] & wdata[1];
                     m_ctl[c][4] = old[4] & wdata[4];
                  end
               endcase
            end
            if (old[0] && eng_done[c]) begin m_ctl[c][1] = 1; m_ctl[c][0] = 0; end
            if (old[0] && eng_err[c])  begin m_ctl[c][4] = 1; m_ctl[c][0] = 0; end
         end
      end
   end

   function automatic logic [31:0] model_rd(input logic [5:0] a);
      int c;
      c = a[5:4];
      if (a[1:0] != 0) return 0;
      case (a[3:2])
         0: return m_src[c];
         1: return m_dst[c];
         2: return m_ctl[c][0] ? {8'h0, eng_remain[c*24 +: 24]} : {8'h0, m_cnt[c]};
         default: return m_ctl[c];
      endcase
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      #1;
      if (rst_n && !ended) begin
         logic exp_irq;
         exp_irq = 0;
         for (int c = 0; c < 4; c++) begin
            exp_irq |= (m_ctl[c][1] & m_ctl[c][2]) | (m_ctl[c][4] & m_ctl[c][5]);
            check("R6 start", eng_start[c], m_ctl[c][0] & ~m_run_d[c]);
            check("R8 run", eng_run[c], m_ctl[c][0]);
            check("R3 burst", eng_burst[c], m_ctl[c][3]);
            check("R3 cfg", eng_cfg[c*26 +: 26], m_ctl[c][31:6]);
            check("R1 src", eng_src[c*32 +: 32], m_src[c]);
            check("R1 dst", eng_dst[c*32 +: 32], m_dst[c]);
            check("R2 cnt", eng_cnt[c*24 +: 24], m_cnt[c]);
         end
         check("R7 irq", irq, exp_irq);
         check("R9 rdata", rdata, model_rd(addr));
      end
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic pulse(input bit is_err, input logic [3:0] ch);
      @(negedge clk);
      if (is_err) eng_err = ch; else eng_done = ch;
      @(negedge clk);
      eng_done = 0; eng_err = 0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      check(tag, rdata, exp);
   endtask

   task automatic finish_run();
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset values
      rd_chk(6'h1C, 32'h0, "R9 reset ctrl");
      rd_chk(6'h18, 32'h0, "R9 reset cnt");
      check("R9 reset irq", irq, 1'b0);

      // R1 register window
      wr(6'h10, 32'hA5A5_0001);
      wr(6'h14, 32'h5A5A_0002);
      wr(6'h18, 32'hFF12_3456);
      wr(6'h00, 32'h1111_0000);
      wr(6'h34, 32'hDEAD_BEEF);
      rd_chk(6'h10, 32'hA5A5_0001, "R1 ch1 src");
      rd_chk(6'h14, 32'h5A5A_0002, "R1 ch1 dst");
      rd_chk(6'h00, 32'h1111_0000, "R1 ch0 src");
      rd_chk(6'h34, 32'hDEAD_BEEF, "R1 ch3 dst");
      rd_chk(6'h18, 32'h0012_3456, "R2 upper bits zero");

      // start ch1, try to set status by writing 1 (R4)
      eng_remain[24 +: 24] = 24'h000777;
      wr(6'h1C, 32'h0000_0C37);
      #1;
      check("R6 start pulse ch1", eng_start, 4'b0010);
      check("R6 src at start", eng_src[63:32], 32'hA5A5_0001);
      rd_chk(6'h1C, 32'h0000_0C25, "R4 status not settable");
      rd_chk(6'h18, 32'h0000_0777, "R2 remain while running");

      // finish event (R5, R7)
      pulse(0, 4'b0010);
      #1;
      check("R7 irq on finish", irq, 1'b1);
      check("R5 run cleared", eng_run[1], 1'b0);
      rd_chk(6'h1C, 32'h0000_0C26, "R5 finish latched");
      rd_chk(6'h18, 32'h0012_3456, "R2 stored count when idle");
      wr(6'h1C, 32'h0000_0C26);
      rd_chk(6'h1C, 32'h0000_0C26, "R4 write one keeps status");
      wr(6'h1C, 32'h0000_0C24);
      rd_chk(6'h1C, 32'h0000_0C24, "R4 write zero clears");
      check("R7 irq cleared", irq, 1'b0);

      // masked error on ch2 (R3, R7)
      wr(6'h2C, 32'h0000_0009);
      check("R3 burst out", eng_burst[2], 1'b1);
      pulse(1, 4'b0100);
      rd_chk(6'h2C, 32'h0000_0018, "R5 error latched");
      check("R7 masked error", irq, 1'b0);
      wr(6'h2C, 32'h0000_0038);
      #1;
      check("R7 error enabled", irq, 1'b1);
      wr(6'h2C, 32'h0000_0028);
      rd_chk(6'h2C, 32'h0000_0028, "R4 error cleared");
      pulse(0, 4'b0100);
      rd_chk(6'h2C, 32'h0000_0028, "R5 event ignored when idle");

      // abort ch3 (R8)
      wr(6'h3C, 32'h0000_0025);
      #1;
      check("R6 start pulse ch3", eng_start, 4'b1000);
      wr(6'h3C, 32'h0000_0024);
      check("R8 run dropped", eng_run[3], 1'b0);
      pulse(0, 4'b1000);
      rd_chk(6'h3C, 32'h0000_0024, "R8 no event after abort");
      check("R8 irq quiet", irq, 1'b0);

      // event and write in the same cycle (R5)
      wr(6'h0C, 32'h0000_0005);
      @(negedge clk);
      addr = 6'h0C; wdata = 32'h0000_0004; wr_en = 1; eng_done = 4'b0001;
      @(negedge clk);
      wr_en = 0; eng_done = 0;
      rd_chk(6'h0C, 32'h0000_0006, "R5 event wins over write");
      check("R7 irq ch0", irq, 1'b1);
      wr(6'h0C, 32'h0000_0004);

      // misaligned access (R9)
      wr(6'h11, 32'hFFFF_FFFF);
      rd_chk(6'h10, 32'hA5A5_0001, "R9 misaligned write ignored");
      rd_chk(6'h11, 32'h0, "R9 misaligned read zero");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule